// File: doc/BRIEF.md
# Statistics Counter Snapshot Reader

This block is the host-facing read side of the traffic statistics in a six-port switch. Every port owns five event counters spread over two address banks. The long counter is four 16-bit words wide and the others are two words wide. Each counter is a saturating register that adds one on every cycle its event strobe is high. A host that wants a coherent multi-word value writes any data to the counter's base address. The block then copies that counter into a 64-bit holding register, raises a busy flag for a few cycles, and makes the copy readable as 16-bit words. Because the copy is taken in one cycle, the upper and lower halves can never tear, however fast the counter is moving.

The same host bus reaches a control/status word. Reading it returns the snapshot-busy and clear-in-progress flags. Writing it clears either all counters or a chosen set of ports.

Top module: `mib_snap_reader`

## Requirements
- R1: After reset, read data is 0, the control word reads 0, and a read of any counter address returns 0 until the first snapshot has been committed.
- R2: Counter c of port p has base address 0x1000 + 0x40·p + {0, 4, 6}[c] for c = 0..2 (bank 0), and 0x1180 + 0x08·p + {0, 2}[c-3] for c = 3..4 (bank 1), with p = 0..5. A host write to a base address captures the value the counter held before that clock edge, whatever the written data.
- R3: Read data is registered and appears the cycle after the read strobe. Word k of the committed snapshot is read at base + k, with word 0 least significant. Counter 0 has 4 words and the others have 2. Snapshot bits above the counter's width read 0. Any address outside the committed counter's words, other than the control word, reads 0.
- R4: The control word is at 0x11F0. Bit 0 (busy) reads 1 for exactly BUSY_CYC cycles after an accepted capture write, and the new snapshot is readable once it drops.
- R5: While busy is set, word reads return the previously committed snapshot at its own address.
- R6: A capture write that arrives while busy is set is ignored and does not change the snapshot that will be committed.
- R7: Writing the control word with bit 2 set clears every counter of every port.
- R8: Writing the control word with bit (p + 3) set clears only the counters of port p.
- R9: Control bit 1 (clear in progress) reads 1 for exactly CLR_CYC cycles after a clearing write.
- R10: A counter stops at its all-ones value instead of wrapping.
- R11: A clear and an event strobe on the same counter in the same cycle leave the counter at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_addr_i | input | 16 | Host word address |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Registered host read data |
| evt_i | input | NUM_PORTS·5 | Event strobes; bit p·5+c increments counter c of port p |

## Verification
The hardest situations to reach are the ones that overlap in time. These are a second capture write landing inside the busy window, a read of the old snapshot while a new one is pending, and a clear that coincides with an event strobe on the same counter. The bench reaches them with directed sequences. It first loads distinct counts into chosen counters, then issues the colliding write, read or strobe on the very next cycle. Saturation is reached by building the bench with narrow counter widths, which keeps the number of events needed small. Random background strobes keep running while snapshots are being polled.

// File: rtl/mib_pkg.sv
package mib_pkg;

    localparam int NUM_CNT      = 5;
    localparam int CNT_IDX_W    = 3;
    localparam int MAX_PORTS    = 16;
    localparam int MAX_PORT_W   = 4;
    localparam int WORD_W       = 16;
    localparam int SNAP_W       = 64;

    localparam logic [15:0] BANK0_BASE   = 16'h1000;
    localparam int          BANK0_STRIDE = 'h40;
    localparam logic [15:0] BANK1_BASE   = 16'h1180;
    localparam int          BANK1_STRIDE = 'h08;
    localparam logic [15:0] CTRL_ADDR    = 16'h11F0;

    localparam int CTRL_BUSY_BIT = 0;
    localparam int CTRL_CLRF_BIT = 1;
    localparam int CTRL_ALL_BIT  = 2;
    localparam int CTRL_PORT_LSB = 3;

    typedef struct packed {
        logic                  hit;
        logic [MAX_PORT_W-1:0] port;
        logic [CNT_IDX_W-1:0]  cnt;
    } cnt_sel_t;

    typedef struct packed {
        logic clr_busy;
        logic snap_busy;
    } status_t;

    typedef enum logic [1:0] {
        RD_NONE,
        RD_CTRL,
        RD_SNAP
    } rd_src_e;

    // counters 3 and 4 live in the second bank
    function automatic logic cnt_in_bank1(int c);
        return c >= 3;
    endfunction

    function automatic logic cnt_is_long(int c);
        return c == 0;
    endfunction

    function automatic int cnt_offset(int c);
        case (c)
            0: return 0;
            1: return 4;
            2: return 6;
            3: return 0;
            default: return 2;
        endcase
    endfunction

    function automatic logic [15:0] cnt_base(int p, int c);
        int v;
        if (cnt_in_bank1(c))
            v = int'(BANK1_BASE) + BANK1_STRIDE * p + cnt_offset(c);
        else
            v = int'(BANK0_BASE) + BANK0_STRIDE * p + cnt_offset(c);
        return v[15:0];
    endfunction

    function automatic cnt_sel_t decode_cnt(logic [15:0] a, int nports);
        cnt_sel_t s;
        s = '0;
        for (int p = 0; p < MAX_PORTS; p++) begin
            for (int c = 0; c < NUM_CNT; c++) begin
                if (p < nports && a == cnt_base(p, c)) begin
                    s.hit  = 1'b1;
                    s.port = p[MAX_PORT_W-1:0];
                    s.cnt  = c[CNT_IDX_W-1:0];
                end
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/mib_sat_counter.sv
module mib_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            cnt_o <= '0;
        else if (inc_i && cnt_o != CNT_MAX)
            cnt_o <= cnt_o + 1'b1;
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cnt_o == CNT_MAX && !clr_i) |=> cnt_o == CNT_MAX);   // R10
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> cnt_o == '0);   // R11
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> (cnt_o - $past(cnt_o)) <= W'(1));   // R10

endmodule

// File: rtl/mib_counter_array.sv
module mib_counter_array
    import mib_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    parameter int SHORT_W   = 32,
    parameter int LONG_W    = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_PORTS*NUM_CNT-1:0] evt_i,
    input  logic [NUM_PORTS-1:0]         clr_port_i,
    input  logic [MAX_PORT_W-1:0]        sel_port_i,
    input  logic [CNT_IDX_W-1:0]         sel_cnt_i,
    output logic [SNAP_W-1:0]            sel_val_o
);

    logic [SNAP_W-1:0] vals [NUM_PORTS][NUM_CNT];

    for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
        for (genvar gc = 0; gc < NUM_CNT; gc++) begin : g_cnt
            localparam int W = cnt_is_long(gc) ? LONG_W : SHORT_W;
            logic [W-1:0] cv;
            mib_sat_counter #(.W(W)) u_cnt (
                .clk   (clk),
                .rst   (rst),
                .inc_i (evt_i[gp*NUM_CNT+gc]),
                .clr_i (clr_port_i[gp]),
                .cnt_o (cv)
            );
            assign vals[gp][gc] = SNAP_W'(cv);
        end
    end

    always_comb begin
        sel_val_o = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            for (int c = 0; c < NUM_CNT; c++) begin
                if (sel_port_i == p[MAX_PORT_W-1:0] && sel_cnt_i == c[CNT_IDX_W-1:0])
                    sel_val_o = vals[p][c];
            end
        end
    end

endmodule

// File: rtl/mib_snapshot.sv
module mib_snapshot
    import mib_pkg::*;
#(
    parameter int BUSY_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  logic [15:0]       trig_base_i,
    input  logic              trig_long_i,
    input  logic [SNAP_W-1:0] trig_val_i,
    output logic              busy_o,
    output logic              vis_valid_o,
    output logic [15:0]       vis_base_o,
    output logic              vis_long_o,
    output logic [SNAP_W-1:0] vis_val_o
);

    localparam int BW = $clog2(BUSY_CYC + 1);

    logic [BW-1:0]     busy_cnt;
    logic [SNAP_W-1:0] pend_val;
    logic [15:0]       pend_base;
    logic              pend_long;

    assign busy_o = (busy_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt    <= '0;
            pend_val    <= '0;
            pend_base   <= '0;
            pend_long   <= 1'b0;
            vis_valid_o <= 1'b0;
            vis_base_o  <= '0;
            vis_long_o  <= 1'b0;
            vis_val_o   <= '0;
        end else if (trig_i && !busy_o) begin
            pend_val  <= trig_val_i;
            pend_base <= trig_base_i;
            pend_long <= trig_long_i;
            busy_cnt  <= BW'(BUSY_CYC);
        end else if (busy_o) begin
            busy_cnt <= busy_cnt - 1'b1;
            if (busy_cnt == BW'(1)) begin
                vis_valid_o <= 1'b1;
                vis_base_o  <= pend_base;
                vis_long_o  <= pend_long;
                vis_val_o   <= pend_val;
            end
        end
    end

    AST_TRIG_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (trig_i && busy_o) |=> ($stable(pend_val) && $stable(pend_base)));   // R6
    AST_OLD_SNAP_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy_cnt > BW'(1)) |=> ($stable(vis_val_o) && $stable(vis_base_o)));   // R5
    AST_BUSY_RAISE: assert property (@(posedge clk) disable iff (rst)
        (trig_i && !busy_o) |=> busy_o);   // R4

endmodule

// File: rtl/mib_snap_reader.sv
module mib_snap_reader
    import mib_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    parameter int SHORT_W   = 32,
    parameter int LONG_W    = 64,
    parameter int BUSY_CYC  = 4,
    parameter int CLR_CYC   = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         host_wr_i,
    input  logic                         host_rd_i,
    input  logic [15:0]                  host_addr_i,
    input  logic [15:0]                  host_wdata_i,
    output logic [15:0]                  host_rdata_o,
    input  logic [NUM_PORTS*NUM_CNT-1:0] evt_i
);

    localparam int CW = $clog2(CLR_CYC + 1);

    cnt_sel_t          dec;
    logic              ctrl_hit;
    logic              ctrl_wr;
    logic [NUM_PORTS-1:0] clr_port;
    logic [SNAP_W-1:0] cap_val;
    logic [CW-1:0]     clr_cnt;
    status_t           status;
    logic              snap_busy;
    logic              vis_valid;
    logic [15:0]       vis_base;
    logic              vis_long;
    logic [SNAP_W-1:0] vis_val;
    logic [15:0]       rel;
    rd_src_e           rd_src;
    logic [15:0]       rd_word;

    assign dec      = decode_cnt(host_addr_i, NUM_PORTS);
    assign ctrl_hit = (host_addr_i == CTRL_ADDR);
    assign ctrl_wr  = host_wr_i && ctrl_hit;

    for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_clr
        assign clr_port[gp] = ctrl_wr &&
            (host_wdata_i[CTRL_ALL_BIT] || host_wdata_i[CTRL_PORT_LSB+gp]);
    end

    mib_counter_array #(
        .NUM_PORTS (NUM_PORTS),
        .SHORT_W   (SHORT_W),
        .LONG_W    (LONG_W)
    ) u_cnts (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt_i),
        .clr_port_i (clr_port),
        .sel_port_i (dec.port),
        .sel_cnt_i  (dec.cnt),
        .sel_val_o  (cap_val)
    );

    mib_snapshot #(.BUSY_CYC(BUSY_CYC)) u_snap (
        .clk         (clk),
        .rst         (rst),
        .trig_i      (host_wr_i && dec.hit),
        .trig_base_i (host_addr_i),
        .trig_long_i (dec.cnt == CNT_IDX_W'(0)),
        .trig_val_i  (cap_val),
        .busy_o      (snap_busy),
        .vis_valid_o (vis_valid),
        .vis_base_o  (vis_base),
        .vis_long_o  (vis_long),
        .vis_val_o   (vis_val)
    );

    always_ff @(posedge clk) begin
        if (rst)
            clr_cnt <= '0;
        else if (|clr_port)
            clr_cnt <= CW'(CLR_CYC);
        else if (clr_cnt != '0)
            clr_cnt <= clr_cnt - 1'b1;
    end

    assign status.snap_busy = snap_busy;
    assign status.clr_busy  = (clr_cnt != '0);

    assign rel = host_addr_i - vis_base;

    always_comb begin
        if (ctrl_hit)
            rd_src = RD_CTRL;
        else if (vis_valid && rel < (vis_long ? 16'd4 : 16'd2))
            rd_src = RD_SNAP;
        else
            rd_src = RD_NONE;
    end

    always_comb begin
        rd_word = '0;
        case (rd_src)
            RD_CTRL: rd_word = {14'd0, status};
            RD_SNAP: begin
                case (rel[1:0])
                    2'd0:    rd_word = vis_val[15:0];
                    2'd1:    rd_word = vis_val[31:16];
                    2'd2:    rd_word = vis_val[47:32];
                    default: rd_word = vis_val[63:48];
                endcase
            end
            default: rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            host_rdata_o <= '0;
        else if (host_rd_i)
            host_rdata_o <= rd_word;
    end

    AST_CLR_FLAG: assert property (@(posedge clk) disable iff (rst)
        (|clr_port) |=> status.clr_busy);   // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !host_rd_i |=> $stable(host_rdata_o));   // R3

endmodule

// File: tb/sim_mib_snap_reader.sv
`timescale 1ns/1ps
module sim_mib_snap_reader;

    localparam int NP = 6;
    localparam int NC = 5;
    localparam int SW = 10;
    localparam int LW = 12;
    localparam int BC = 4;
    localparam int CC = 3;
    localparam logic [15:0] CTRL = 16'h11F0;

    typedef logic [NP*NC-1:0] ev_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr = 1'b0, rd = 1'b0;
    logic [15:0] addr = '0, wdata = '0;
    logic [15:0] rdata;
    ev_t ev = '0;

    longint mdl [NP][NC];
    int errs = 0;
    int total = 0;

    always #2 clk = ~clk;

    mib_snap_reader #(
        .NUM_PORTS(NP), .SHORT_W(SW), .LONG_W(LW), .BUSY_CYC(BC), .CLR_CYC(CC)
    ) u0 (
        .clk(clk), .rst(rst), .host_wr_i(wr), .host_rd_i(rd),
        .host_addr_i(addr), .host_wdata_i(wdata), .host_rdata_o(rdata), .evt_i(ev)
    );

    function automatic longint cmax(int c);
        return (c == 0) ? ((64'd1 << LW) - 1) : ((64'd1 << SW) - 1);
    endfunction

    function automatic logic [15:0] cbase(int p, int c);
        int offs [NC] = '{0, 4, 6, 0, 2};
        int v;
        v = (c >= 3) ? ('h1180 + 8 * p) : ('h1000 + 'h40 * p);
        v = v + offs[c];
        return v[15:0];
    endfunction

    function automatic ev_t evbit(int p, int c);
        ev_t e;
        e = '0;
        e[p*NC+c] = 1'b1;
        return e;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic r, input logic [15:0] a,
                       input logic [15:0] d, input ev_t e);
        @(negedge clk);
        wr = w; rd = r; addr = a; wdata = d; ev = e;
        @(posedge clk);
        for (int p = 0; p < NP; p++) begin
            for (int c = 0; c < NC; c++) begin
                if (w && a == CTRL && (d[2] || d[p+3]))
                    mdl[p][c] = 0;
                else if (e[p*NC+c] && mdl[p][c] < cmax(c))
                    mdl[p][c] = mdl[p][c] + 1;
            end
        end
        #1;
        wr = 1'b0; rd = 1'b0; ev = '0;
    endtask

    task automatic idle(int n, bit noise);
        for (int i = 0; i < n; i++)
            cyc(1'b0, 1'b0, 16'h0, 16'h0, noise ? ev_t'($urandom) : ev_t'(0));
    endtask

    task automatic pulse(int p, int c, int n);
        for (int i = 0; i < n; i++)
            cyc(1'b0, 1'b0, 16'h0, 16'h0, evbit(p, c));
    endtask

    task automatic wait_idle(output int nbusy, input bit noise);
        nbusy = 0;
        for (int i = 0; i < 20; i++) begin
            cyc(1'b0, 1'b1, CTRL, 16'h0, noise ? ev_t'($urandom) : ev_t'(0));
            if (rdata[0]) nbusy++;
            else break;
        end
    endtask

    task automatic read_words(int p, int c, output longint v, input bit noise);
        logic [63:0] acc;
        int n;
        acc = '0;
        n = (c == 0) ? 4 : 2;
        for (int k = 0; k < n; k++) begin
            cyc(1'b0, 1'b1, cbase(p, c) + 16'(k), 16'h0, noise ? ev_t'($urandom) : ev_t'(0));
            acc[16*k +: 16] = rdata;
        end
        v = longint'(acc);
    endtask

    task automatic snap(int p, int c, output longint v, output int nbusy, input bit noise);
        cyc(1'b1, 1'b0, cbase(p, c), 16'($urandom), noise ? ev_t'($urandom) : ev_t'(0));
        wait_idle(nbusy, noise);
        read_words(p, c, v, noise);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        total++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, total);
        $finish;
    end

    initial begin
        longint v, exp, va;
        int nb;
        void'($urandom(32'd20240611));
        for (int p = 0; p < NP; p++)
            for (int c = 0; c < NC; c++)
                mdl[p][c] = 0;

        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        chk("R1 rdata after reset", rdata, 0);
        cyc(1'b0, 1'b1, CTRL, 16'h0, '0);
        chk("R1 control word after reset", rdata, 0);
        cyc(1'b0, 1'b1, 16'h1000, 16'h0, '0);
        chk("R1 no snapshot committed", rdata, 0);
        snap(2, 3, v, nb, 1'b0);
        chk("R1 counter zero after reset", v, 0);

        // R2 R4: random traffic, random counter, random written data
        for (int it = 0; it < 16; it++) begin
            int p, c;
            idle(5 + int'($urandom % 40), 1'b1);
            p = int'($urandom % NP);
            c = int'($urandom % NC);
            exp = mdl[p][c];
            snap(p, c, v, nb, 1'b1);
            chk("R2 snapshot value", v, exp);
            chk("R4 busy cycles", nb, BC);
        end

        // R3: words beyond the counter and unmapped addresses
        snap(1, 1, v, nb, 1'b0);
        cyc(1'b0, 1'b1, cbase(1, 1) + 16'd2, 16'h0, '0);
        chk("R3 word past short counter", rdata, 0);
        cyc(1'b0, 1'b1, 16'h2000, 16'h0, '0);
        chk("R3 unmapped address", rdata, 0);

        // R7 R9: clear everything, watch clear-in-progress flag
        cyc(1'b1, 1'b0, CTRL, 16'h0004, '0);
        wait_clr: begin
            int n;
            n = 0;
            for (int i = 0; i < 20; i++) begin
                cyc(1'b0, 1'b1, CTRL, 16'h0, '0);
                if (rdata[1]) n++;
                else break;
            end
            chk("R9 clear flag cycles", n, CC);
        end
        snap(0, 0, v, nb, 1'b0);
        chk("R7 long counter cleared", v, 0);
        snap(5, 4, v, nb, 1'b0);
        chk("R7 bank1 counter cleared", v, 0);

        // R5: old snapshot readable while a new one is pending
        pulse(0, 3, 7);
        pulse(1, 4, 9);
        pulse(2, 1, 5);
        snap(0, 3, v, nb, 1'b0);
        chk("R2 directed value", v, 7);
        cyc(1'b1, 1'b0, cbase(1, 4), 16'hFFFF, '0);
        cyc(1'b0, 1'b1, cbase(0, 3), 16'h0, '0);
        chk("R5 previous snapshot during busy", rdata, 7);
        wait_idle(nb, 1'b0);
        cyc(1'b0, 1'b1, cbase(1, 4), 16'h0, '0);
        chk("R4 new snapshot after busy", rdata, 9);
        cyc(1'b0, 1'b1, cbase(0, 3), 16'h0, '0);
        chk("R3 old base no longer mapped", rdata, 0);

        // R6: second capture inside busy is dropped
        cyc(1'b1, 1'b0, cbase(0, 3), 16'h1234, '0);
        cyc(1'b1, 1'b0, cbase(2, 1), 16'h5678, '0);
        wait_idle(nb, 1'b0);
        cyc(1'b0, 1'b1, cbase(2, 1), 16'h0, '0);
        chk("R6 ignored capture not visible", rdata, 0);
        cyc(1'b0, 1'b1, cbase(0, 3), 16'h0, '0);
        chk("R6 first capture kept", rdata, 7);

        // R8: clear one port only
        pulse(3, 1, 6);
        cyc(1'b1, 1'b0, CTRL, 16'h0020, '0);
        snap(2, 1, v, nb, 1'b0);
        chk("R8 cleared port", v, 0);
        snap(3, 1, v, nb, 1'b0);
        chk("R8 other port kept", v, 6);
        snap(1, 4, v, nb, 1'b0);
        chk("R8 port1 bank1 kept", v, 9);

        // R11: clear and strobe together
        pulse(4, 2, 3);
        cyc(1'b1, 1'b0, CTRL, 16'h0080, evbit(4, 2));
        snap(4, 2, v, nb, 1'b0);
        chk("R11 clear beats increment", v, 0);

        // R10: saturation of short and long counters
        pulse(5, 1, 1100);
        snap(5, 1, v, nb, 1'b0);
        chk("R10 short saturates", v, 64'd1023);
        pulse(5, 0, 4200);
        snap(5, 0, va, nb, 1'b0);
        chk("R10 long saturates", va, 64'd4095);
        exp = mdl[5][0];
        chk("R10 model agrees", va, exp);

        $display("Result: errors=%0d of %0d checks", errs, total);
        $finish;
    end

endmodule